// File: doc/BRIEF.md
# Stream-Mapped Special Register Port

This block sits beside the register file of a small command-processing microcontroller and serves the four highest register indices of its 5-bit register space. The core reads and writes these indices like any other register. The block does not store them, except for a remainder count. Instead it maps each access onto a stream. A source read of a stream-backed index takes one word from the incoming command stream or from one of two read-data FIFOs, one fed by memory reads and one by register reads. A destination write either sets an outgoing address pointer or pushes an address/data pair to an output stream.

One index means different things as a source and as a destination. Two separate indices set the outgoing address. One marks later data writes as trusted. The other marks them as subject to a protection check against a fixed protected address window. A checked write that lands inside the window is not sent. Instead it raises a sticky fault flag. Every data write moves the pointer forward by one, so a run of data writes fills consecutive register addresses. The remainder register holds the count of extra repeated moves. The core loads it, reads it, and steps it down once per extra move.

When a source is empty, a read stalls the core. When the output stream is not ready, a data write stalls the core.

Top module: `spr_stream_port`

## Requirements
- R1: After reset the remainder count is 0, the fault flag is 0, the address pointer is 0 and unchecked, and no output word is offered.
- R2: Only indices 0x1C to 0x1F are served. A read of any lower index returns 0, takes no word from any source and does not stall. A write to any lower index emits nothing and leaves the remainder unchanged.
- R3: A write to index 0x1D loads the address pointer from the low ADDR_W bits of the write data and marks the pointer unchecked.
- R4: A write to index 0x1E loads the address pointer the same way and marks it checked. A checked write to an address outside the protected window is emitted normally.
- R5: A write to index 0x1F offers out_addr equal to the pointer and out_data equal to the write data. On acceptance the pointer increments by one and wraps modulo 2^ADDR_W.
- R6: While a 0x1F write is offered and out_ready is 0, wr_stall is 1, the offered word stays unchanged, and the pointer does not advance.
- R7: A 0x1F write with a checked pointer inside [PROT_LO, PROT_HI] (inclusive) is not offered and does not stall. It sets the sticky fault flag and still increments the pointer. The flag stays set until reset.
- R8: A read of 0x1F returns the command-stream word. A read of 0x1D returns the memory-read FIFO word. A read of 0x1E returns the register-read FIFO word. Each value is returned in the same cycle. Only the ready of the addressed source is raised.
- R9: A read of a stream-backed index whose source has valid low raises rd_stall and no ready until valid rises. The word is then returned without a stall.
- R10: A read of 0x1C returns the remainder value without stalling. A write to 0x1C loads it, and the new value is visible from the next cycle.
- R11: Each cycle with xmov_step high decrements a nonzero remainder by one, and the remainder stays at 0 when it is 0. A write to 0x1C in the same cycle takes precedence over the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Source read request |
| rd_idx | input | 5 | Source register index |
| rd_data | output | DATA_W | Value returned for the read |
| rd_stall | output | 1 | Read source empty, core must hold |
| wr_en | input | 1 | Destination write request |
| wr_idx | input | 5 | Destination register index |
| wr_data | input | DATA_W | Value written |
| wr_stall | output | 1 | Output stream busy, core must hold |
| xmov_step | input | 1 | One extra repeated move performed |
| rem_count | output | DATA_W | Current remainder value |
| cmd_valid | input | 1 | Command stream word available |
| cmd_data | input | DATA_W | Command stream word |
| cmd_ready | output | 1 | Command stream word taken |
| mrd_valid | input | 1 | Memory-read FIFO word available |
| mrd_data | input | DATA_W | Memory-read FIFO word |
| mrd_ready | output | 1 | Memory-read FIFO word taken |
| rrd_valid | input | 1 | Register-read FIFO word available |
| rrd_data | input | DATA_W | Register-read FIFO word |
| rrd_ready | output | 1 | Register-read FIFO word taken |
| out_valid | output | 1 | Output address/data pair offered |
| out_addr | output | ADDR_W | Target register address |
| out_data | output | DATA_W | Data for the target |
| out_ready | input | 1 | Output stream accepts the pair |
| prot_fault | output | 1 | Sticky protected-write fault |

## Verification
The hold check on the output stream assumes the core keeps wr_en, wr_idx and wr_data steady while wr_stall is high. The bench write task waits on wr_stall before it releases the port, so that condition is always met. The read side assumes a stalled read is held until data arrives. The stall scenario holds rd_en across several empty cycles before it raises valid. Source words are changed only after the cycle in which they are popped.

// File: rtl/spr_pkg.sv
package spr_pkg;
    localparam int SPR_IDX_W = 5;

    // special indices at the top of the register space
    localparam logic [SPR_IDX_W-1:0] IDX_REM    = 5'h1C;
    localparam logic [SPR_IDX_W-1:0] IDX_MEMQ   = 5'h1D; // src: mem FIFO, dst: raw address
    localparam logic [SPR_IDX_W-1:0] IDX_REGQ   = 5'h1E; // src: reg FIFO, dst: checked address
    localparam logic [SPR_IDX_W-1:0] IDX_STREAM = 5'h1F; // src: command in, dst: data out
endpackage

// File: rtl/spr_range_chk.sv
module spr_range_chk #(
    parameter int          ADDR_W  = 16,
    parameter int unsigned PROT_LO = 'h100,
    parameter int unsigned PROT_HI = 'h1FF
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] LO_V = ADDR_W'(PROT_LO);
    localparam logic [ADDR_W-1:0] HI_V = ADDR_W'(PROT_HI);
    localparam bit LO_OPEN = (PROT_LO == 0);
    localparam bit HI_OPEN = (longint'(PROT_HI) >= ((longint'(1) << ADDR_W) - 1));

    logic ge_lo;
    logic le_hi;

    generate
        if (LO_OPEN) begin : g_lo_open
            assign ge_lo = 1'b1;
        end else begin : g_lo_cmp
            assign ge_lo = (addr >= LO_V);
        end
        if (HI_OPEN) begin : g_hi_open
            assign le_hi = 1'b1;
        end else begin : g_hi_cmp
            assign le_hi = (addr <= HI_V);
        end
    endgenerate

    assign hit = ge_lo && le_hi;
endmodule

// File: rtl/spr_src_mux.sv
module spr_src_mux
    import spr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 rd_en,
    input  logic [SPR_IDX_W-1:0] rd_idx,
    input  logic [DATA_W-1:0]    rem_val,
    input  logic                 cmd_valid,
    input  logic [DATA_W-1:0]    cmd_data,
    input  logic                 mrd_valid,
    input  logic [DATA_W-1:0]    mrd_data,
    input  logic                 rrd_valid,
    input  logic [DATA_W-1:0]    rrd_data,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_stall,
    output logic                 cmd_ready,
    output logic                 mrd_ready,
    output logic                 rrd_ready
);
    always_comb begin
        rd_data   = '0;
        rd_stall  = 1'b0;
        cmd_ready = 1'b0;
        mrd_ready = 1'b0;
        rrd_ready = 1'b0;
        if (rd_en) begin
            case (rd_idx)
                IDX_REM: rd_data = rem_val;
                IDX_MEMQ: begin
                    rd_data   = mrd_data;
                    mrd_ready = mrd_valid;
                    rd_stall  = !mrd_valid;
                end
                IDX_REGQ: begin
                    rd_data   = rrd_data;
                    rrd_ready = rrd_valid;
                    rd_stall  = !rrd_valid;
                end
                IDX_STREAM: begin
                    rd_data   = cmd_data;
                    cmd_ready = cmd_valid;
                    rd_stall  = !cmd_valid;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/spr_stream_port.sv
module spr_stream_port
    import spr_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter int          ADDR_W  = 16,
    parameter int unsigned PROT_LO = 'h100,
    parameter int unsigned PROT_HI = 'h1FF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic [SPR_IDX_W-1:0] rd_idx,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_stall,
    input  logic                 wr_en,
    input  logic [SPR_IDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0]    wr_data,
    output logic                 wr_stall,
    input  logic                 xmov_step,
    output logic [DATA_W-1:0]    rem_count,
    input  logic                 cmd_valid,
    input  logic [DATA_W-1:0]    cmd_data,
    output logic                 cmd_ready,
    input  logic                 mrd_valid,
    input  logic [DATA_W-1:0]    mrd_data,
    output logic                 mrd_ready,
    input  logic                 rrd_valid,
    input  logic [DATA_W-1:0]    rrd_data,
    output logic                 rrd_ready,
    output logic                 out_valid,
    output logic [ADDR_W-1:0]    out_addr,
    output logic [DATA_W-1:0]    out_data,
    input  logic                 out_ready,
    output logic                 prot_fault
);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
    localparam logic [DATA_W-1:0] REM_ONE  = DATA_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              chk;
        logic [DATA_W-1:0] rem;
        logic              fault;
    } port_st_t;

    port_st_t st_d, st_q;
    logic     in_window;
    logic     data_wr;
    logic     blocked;
    logic     rem_load;

    spr_range_chk #(
        .ADDR_W (ADDR_W),
        .PROT_LO(PROT_LO),
        .PROT_HI(PROT_HI)
    ) u_range (
        .addr(st_q.addr),
        .hit (in_window)
    );

    spr_src_mux #(
        .DATA_W(DATA_W)
    ) u_src (
        .rd_en    (rd_en),
        .rd_idx   (rd_idx),
        .rem_val  (st_q.rem),
        .cmd_valid(cmd_valid),
        .cmd_data (cmd_data),
        .mrd_valid(mrd_valid),
        .mrd_data (mrd_data),
        .rrd_valid(rrd_valid),
        .rrd_data (rrd_data),
        .rd_data  (rd_data),
        .rd_stall (rd_stall),
        .cmd_ready(cmd_ready),
        .mrd_ready(mrd_ready),
        .rrd_ready(rrd_ready)
    );

    always_comb begin
        st_d     = st_q;
        data_wr  = wr_en && (wr_idx == IDX_STREAM);
        blocked  = data_wr && st_q.chk && in_window;
        rem_load = wr_en && (wr_idx == IDX_REM);
        out_valid = data_wr && !blocked;
        wr_stall  = out_valid && !out_ready;

        if (rem_load) begin
            st_d.rem = wr_data;
        end else if (xmov_step && (st_q.rem != '0)) begin
            st_d.rem = st_q.rem - REM_ONE;
        end

        if (wr_en && (wr_idx == IDX_MEMQ)) begin
            st_d.addr = wr_data[ADDR_W-1:0];
            st_d.chk  = 1'b0;
        end else if (wr_en && (wr_idx == IDX_REGQ)) begin
            st_d.addr = wr_data[ADDR_W-1:0];
            st_d.chk  = 1'b1;
        end else if (blocked || (out_valid && out_ready)) begin
            st_d.addr = st_q.addr + ADDR_ONE;
        end

        if (blocked) begin
            st_d.fault = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_addr   = st_q.addr;
    assign out_data   = wr_data;
    assign rem_count  = st_q.rem;
    assign prot_fault = st_q.fault;

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (st_q.addr == $past(st_q.addr) + ADDR_ONE));

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_data)));

    // R7
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_fault |=> prot_fault);

    // R7
    drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |-> (!out_valid && !wr_stall) ##1 prot_fault);

    // R9
    stall_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stall |-> !(cmd_ready || mrd_ready || rrd_ready));

    // R11
    rem_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_count == '0 && xmov_step && !rem_load) |=> (rem_count == '0));

    // R11
    rem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_count != '0 && xmov_step && !rem_load) |=> (rem_count == $past(rem_count) - REM_ONE));
endmodule

// File: tb/spr_stream_port_tb.sv
module spr_stream_port_tb;
    localparam int DW = 32;
    localparam int AW = 16;
    localparam logic [AW-1:0] WLO = 16'h0100;
    localparam logic [AW-1:0] WHI = 16'h01FF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_en = 1'b0, wr_en = 1'b0, xmov_step = 1'b0;
    logic [4:0] rd_idx = '0, wr_idx = '0;
    logic [DW-1:0] wr_data = '0, rd_data, rem_count;
    logic rd_stall, wr_stall;
    logic cmd_valid = 1'b0, mrd_valid = 1'b0, rrd_valid = 1'b0;
    logic [DW-1:0] cmd_data = '0, mrd_data = '0, rrd_data = '0;
    logic cmd_ready, mrd_ready, rrd_ready;
    logic out_valid, out_ready = 1'b1, prot_fault;
    logic [AW-1:0] out_addr;
    logic [DW-1:0] out_data;

    int n_chk = 0;
    int n_fail = 0;
    logic [AW+DW-1:0] exp_q[$];
    logic [AW+DW-1:0] mon_e;
    logic [AW-1:0] m_addr = '0;
    logic m_chk = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    spr_stream_port u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .rd_stall(rd_stall),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_stall(wr_stall),
        .xmov_step(xmov_step), .rem_count(rem_count),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
        .mrd_valid(mrd_valid), .mrd_data(mrd_data), .mrd_ready(mrd_ready),
        .rrd_valid(rrd_valid), .rrd_data(rrd_data), .rrd_ready(rrd_ready),
        .out_valid(out_valid), .out_addr(out_addr), .out_data(out_data),
        .out_ready(out_ready), .prot_fault(prot_fault)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // scoreboard monitor: compares each accepted output word
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected output", 64'({out_addr, out_data}), 64'h0);
            end else begin
                mon_e = exp_q.pop_front();
                check({out_addr, out_data} == mon_e, "R5 output word",
                      64'({out_addr, out_data}), 64'(mon_e));
            end
        end
    end

    task automatic do_write(input logic [4:0] idx, input logic [DW-1:0] d);
        bit drop;
        drop = 1'b0;
        @(posedge clk); #1;
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        if (idx == 5'h1F) begin
            drop = m_chk && (m_addr >= WLO) && (m_addr <= WHI);
            if (!drop) exp_q.push_back({m_addr, d});
        end
        @(negedge clk);
        if (idx == 5'h1F)
            check(out_valid == !drop, drop ? "R7 dropped write offered" : "R5 write not offered",
                  64'(out_valid), 64'(!drop));
        else
            check(!out_valid, (idx < 5'h1C) ? "R2 low index emitted" : "R3 config write emitted",
                  64'(out_valid), 64'h0);
        while (wr_stall) @(negedge clk);
        @(posedge clk); #1;
        wr_en = 1'b0;
        if (idx == 5'h1D) begin m_addr = d[AW-1:0]; m_chk = 1'b0; end
        if (idx == 5'h1E) begin m_addr = d[AW-1:0]; m_chk = 1'b1; end
        if (idx == 5'h1F) m_addr = m_addr + 16'd1;
    endtask

    task automatic rd_check(input logic [4:0] idx, input logic [DW-1:0] exp, input string tag);
        @(posedge clk); #1;
        rd_en = 1'b1; rd_idx = idx;
        @(negedge clk);
        check(!rd_stall, tag, 64'(rd_stall), 64'h0);
        check(rd_data == exp, tag, 64'(rd_data), 64'(exp));
        check({cmd_ready, mrd_ready, rrd_ready} ==
              {idx == 5'h1F, idx == 5'h1D, idx == 5'h1E}, tag,
              64'({cmd_ready, mrd_ready, rrd_ready}),
              64'({idx == 5'h1F, idx == 5'h1D, idx == 5'h1E}));
        @(posedge clk); #1;
        rd_en = 1'b0; cmd_valid = 1'b0; mrd_valid = 1'b0; rrd_valid = 1'b0;
    endtask

    task automatic step_n(input int n);
        @(posedge clk); #1;
        xmov_step = 1'b1;
        repeat (n) @(posedge clk);
        #1 xmov_step = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 64'h0, 64'h1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rem_count == '0, "R1 remainder", 64'(rem_count), 64'h0);
        check(!prot_fault, "R1 fault", 64'(prot_fault), 64'h0);
        check(!out_valid && !rd_stall && !wr_stall, "R1 idle", 64'(out_valid), 64'h0);

        // R3 unchecked pointer, R5 consecutive data writes
        do_write(5'h1D, 32'h0000_0040);
        do_write(5'h1F, 32'hA5A5_0001);
        do_write(5'h1F, 32'hA5A5_0002);
        // R4 checked pointer outside the window
        do_write(5'h1E, 32'h0000_0200);
        do_write(5'h1F, 32'hA5A5_0003);
        @(negedge clk);
        check(!prot_fault, "R4 fault outside window", 64'(prot_fault), 64'h0);

        // R7 checked pointer inside the window, crossing the upper edge
        do_write(5'h1E, 32'h0000_01FE);
        do_write(5'h1F, 32'hA5A5_0004);
        do_write(5'h1F, 32'hA5A5_0005);
        do_write(5'h1F, 32'hA5A5_0006);
        @(negedge clk);
        check(prot_fault, "R7 fault set", 64'(prot_fault), 64'h1);

        // R3 unchecked pointer inside the window is emitted, fault stays
        do_write(5'h1D, 32'h0000_0150);
        do_write(5'h1F, 32'hA5A5_0007);
        @(negedge clk);
        check(prot_fault, "R7 fault sticky", 64'(prot_fault), 64'h1);

        // R5 pointer wrap
        do_write(5'h1D, 32'h0000_FFFF);
        do_write(5'h1F, 32'hA5A5_0008);
        do_write(5'h1F, 32'hA5A5_0009);

        // R6 output back-pressure
        do_write(5'h1D, 32'h0000_0300);
        out_ready = 1'b0;
        @(posedge clk); #1;
        wr_en = 1'b1; wr_idx = 5'h1F; wr_data = 32'h0000_BEEF;
        exp_q.push_back({16'h0300, 32'h0000_BEEF});
        @(negedge clk);
        check(wr_stall && out_valid, "R6 stall raised", 64'(wr_stall), 64'h1);
        @(negedge clk);
        check(wr_stall, "R6 stall held", 64'(wr_stall), 64'h1);
        check(out_addr == 16'h0300, "R6 pointer held", 64'(out_addr), 64'h300);
        @(posedge clk); #1;
        out_ready = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
        m_addr = 16'h0301;
        do_write(5'h1F, 32'h0000_BEF0);
        check(exp_q.size() == 0, "R5 all words seen", 64'(exp_q.size()), 64'h0);

        // R10 remainder load/read, R11 stepping
        do_write(5'h1C, 32'd3);
        rd_check(5'h1C, 32'd3, "R10 remainder read");
        step_n(2);
        rd_check(5'h1C, 32'd1, "R11 step down");
        step_n(3);
        rd_check(5'h1C, 32'd0, "R11 floor at zero");
        @(posedge clk); #1;
        wr_en = 1'b1; wr_idx = 5'h1C; wr_data = 32'd9; xmov_step = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; xmov_step = 1'b0;
        rd_check(5'h1C, 32'd9, "R11 load beats step");
        step_n(1);
        @(negedge clk);
        check(rem_count == 32'd8, "R11 single step", 64'(rem_count), 64'd8);

        // R8 source reads, all sources offering
        cmd_valid = 1'b1; cmd_data = 32'hC0DE_0001;
        mrd_valid = 1'b1; mrd_data = 32'h3E30_0002;
        rrd_valid = 1'b1; rrd_data = 32'h9E90_0003;
        rd_check(5'h1F, 32'hC0DE_0001, "R8 command read");
        mrd_valid = 1'b1; mrd_data = 32'h3E30_0004;
        rrd_valid = 1'b1; rrd_data = 32'h9E90_0005;
        rd_check(5'h1D, 32'h3E30_0004, "R8 memory FIFO read");
        rrd_valid = 1'b1; rrd_data = 32'h9E90_0006;
        rd_check(5'h1E, 32'h9E90_0006, "R8 register FIFO read");

        // R9 empty source stalls
        @(posedge clk); #1;
        rd_en = 1'b1; rd_idx = 5'h1F;
        @(negedge clk);
        check(rd_stall && !cmd_ready, "R9 stall on empty", 64'(rd_stall), 64'h1);
        @(negedge clk);
        check(rd_stall, "R9 stall held", 64'(rd_stall), 64'h1);
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_data = 32'h0BAD_F00D;
        @(negedge clk);
        check(!rd_stall && cmd_ready, "R9 released", 64'(rd_stall), 64'h0);
        check(rd_data == 32'h0BAD_F00D, "R9 data", 64'(rd_data), 64'h0BADF00D);
        @(posedge clk); #1;
        rd_en = 1'b0; cmd_valid = 1'b0;

        // R2 low indices ignored
        cmd_valid = 1'b1; mrd_valid = 1'b1; rrd_valid = 1'b1;
        rd_check(5'h05, 32'h0, "R2 low index read");
        do_write(5'h05, 32'h0000_1234);
        rd_check(5'h1C, 32'd8, "R2 remainder untouched");

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R5 scoreboard drained", 64'(exp_q.size()), 64'h0);
        finish_run();
    end
endmodule